// File: doc/BRIEF.md
# Match-Compare Event Timer

This block is a programmable event timer. A free-running up-counter advances on a prescaled tick and is compared against a software-loaded match value. When a tick brings the count onto the match value, the block sends a single-cycle expiry pulse to the interrupt controller. Software arms the next event by reading the live count, adding a delay, and writing the sum back as an absolute match value. The count wraps modulo 2^CNT_W, so a match value below the current count is reached after the wrap.

Software reaches every control through a plain memory-mapped register port. This port has an address, write data, a write strobe and a read-data output that is decoded from the address in the same cycle. Neither side has a stream, so there is no valid/ready pair and no back-pressure.

The map has these registers:
- Match value, offset 0x00, read/write.
- Count, offset 0x04, read-only.
- Control, offset 0x08. Bit 0 is the run bit and bit 1 is the return-to-zero-on-match bit.
- Clear, offset 0x0C, write-only.
- Lock, offset 0x20. Bit 0 is the lock bit.
- Divider, offset 0x34. Bits [1:0] hold the divider code.

Top module: `evtimer_top`

## Requirements
- R1: After reset the count reads 0, the match value reads all-ones, control reads 0, the divider code reads 0, lock reads 0 and the expiry output is low.
- R2: While control bit 0 is 1 the count rises by one on each tick. While control bit 0 is 0 the count holds and no ticks are produced.
- R3: A divider code n (0 to 3, written to bits [1:0] at offset 0x34) makes one tick every n+1 clocks while running. The first tick comes n+1 clocks after the edge that sets the run bit.
- R4: A write of any value to offset 0x0C sets the count to 0 at that edge and restarts the divider phase. If a tick falls on the same edge, the clear wins, and that edge produces no expiry pulse.
- R5: The expiry output is high for exactly one clock. That clock is the first clock in which the count reads equal to the match value after a tick brought it there.
- R6: The expiry output does not pulse when the count and match become equal without a tick. This covers a match write equal to the count and a clear to 0 while the match value is 0.
- R7: When control bit 1 is 1, the tick after a match loads 0 into the count. When control bit 1 is 0, the count runs on past the match value.
- R8: The count wraps from all-ones to 0. A match value below the current count is reached after the wrap.
- R9: While lock bit 0 (offset 0x20) is 1, writes to the match, control, clear and divider registers are ignored. The lock register itself always accepts writes.
- R10: Writes to the count at offset 0x04 have no effect. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle high |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| expire_o | output | 1 | One-cycle expiry pulse |

## Verification
A software clear and a prescaled tick can fall on the same clock edge. The bench provokes this with a match value of 4 and issues the clear write on the edge that would move the count from 3 to 4. It checks that the count reads 0 and that no pulse appears after that edge. It then checks that the event still fires exactly four ticks later.

// File: rtl/evtimer_pkg.sv
package evtimer_pkg;
  localparam int BUS_AW = 8;
  localparam int BUS_DW = 32;

  localparam logic [BUS_AW-1:0] OFS_MATCH = 8'h00;
  localparam logic [BUS_AW-1:0] OFS_COUNT = 8'h04;
  localparam logic [BUS_AW-1:0] OFS_CTRL  = 8'h08;
  localparam logic [BUS_AW-1:0] OFS_CLEAR = 8'h0C;
  localparam logic [BUS_AW-1:0] OFS_LOCK  = 8'h20;
  localparam logic [BUS_AW-1:0] OFS_DIV   = 8'h34;

  typedef struct packed {
    logic zero_on_match;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/evtimer_regs.sv
module evtimer_regs
  import evtimer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] addr,
  input  logic [BUS_DW-1:0] wdata,
  input  logic              we,
  input  logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  match_q,
  output ctrl_t             ctrl_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              lock_q,
  output logic              clear_pulse,
  output logic [BUS_DW-1:0] rdata
);
  logic wr_ok;
  logic unused_wbits;

  assign unused_wbits = ^wdata;
  assign wr_ok        = we && !lock_q;
  assign clear_pulse  = wr_ok && (addr == OFS_CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (we && addr == OFS_LOCK) begin
      lock_q <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '1;
      ctrl_q  <= '0;
      div_q   <= '0;
    end else if (wr_ok) begin
      case (addr)
        OFS_MATCH: match_q <= wdata[CNT_W-1:0];
        OFS_CTRL:  ctrl_q  <= ctrl_t'(wdata[1:0]);
        OFS_DIV:   div_q   <= wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_MATCH: rdata = BUS_DW'(match_q);
      OFS_COUNT: rdata = BUS_DW'(count);
      OFS_CTRL:  rdata = BUS_DW'(ctrl_q);
      OFS_LOCK:  rdata = BUS_DW'(lock_q);
      OFS_DIV:   rdata = BUS_DW'(div_q);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/evtimer_prescale.sv
module evtimer_prescale #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] code,
  output logic             tick
);
  logic [DIV_W-1:0] phase_q;

  assign tick = run && (phase_q == code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart || !run || phase_q == code) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/evtimer_core.sv
module evtimer_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic             zero_on_match,
  input  logic [CNT_W-1:0] match,
  output logic [CNT_W-1:0] count_q,
  output logic             expire_q
);
  logic [CNT_W-1:0] next_cnt;
  logic             at_match;

  assign at_match = (count_q == match);
  assign next_cnt = (zero_on_match && at_match) ? '0 : count_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      expire_q <= 1'b0;
    end else if (clear) begin
      count_q  <= '0;
      expire_q <= 1'b0;
    end else if (tick) begin
      count_q  <= next_cnt;
      expire_q <= (next_cnt == match) && (next_cnt != count_q);
    end else begin
      expire_q <= 1'b0;
    end
  end
endmodule

// File: rtl/evtimer_top.sv
module evtimer_top
  import evtimer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_we,
  output logic [31:0] bus_rdata,
  output logic        expire_o
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] match_q;
  ctrl_t            ctrl_q;
  logic [DIV_W-1:0] div_q;
  logic             lock_q;
  logic             clear_pulse;
  logic             tick;
  logic             run;
  logic             clr_on;

  assign run    = ctrl_q.run;
  assign clr_on = ctrl_q.zero_on_match;

  evtimer_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
    .count(count_q), .match_q(match_q), .ctrl_q(ctrl_q), .div_q(div_q),
    .lock_q(lock_q), .clear_pulse(clear_pulse), .rdata(bus_rdata)
  );

  evtimer_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(clear_pulse),
    .code(div_q), .tick(tick)
  );

  evtimer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clear(clear_pulse),
    .zero_on_match(clr_on), .match(match_q), .count_q(count_q),
    .expire_q(expire_o)
  );
endmodule

// File: rtl/evtimer_chk.sv
module evtimer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic             expire_o,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] match_q,
  input logic             lock_q,
  input logic             run,
  input logic             clr_on,
  input logic             tick,
  input logic             clear_pulse
);
  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o);

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_pulse |=> (count_q == '0) && !expire_o);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear_pulse) |=> $stable(count_q));

  // R9
  locked_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && bus_we) |=> $stable(match_q));

  // R6
  no_tick_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !expire_o);

  // R7
  zero_after_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clear_pulse && clr_on && count_q == match_q) |=> (count_q == '0));
endmodule

bind evtimer_top evtimer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .expire_o(expire_o),
  .count_q(count_q), .match_q(match_q), .lock_q(lock_q), .run(run),
  .clr_on(clr_on), .tick(tick), .clear_pulse(clear_pulse)
);

// File: tb/evtimer_top_tb.sv
module evtimer_top_tb;
  localparam logic [7:0] A_MATCH = 8'h00, A_COUNT = 8'h04, A_CTRL = 8'h08,
                         A_CLEAR = 8'h0C, A_LOCK = 8'h20, A_DIV = 8'h34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  a_addr = '0, b_addr = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic        a_we = 1'b0, b_we = 1'b0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_exp, b_exp;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evtimer_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(a_addr), .bus_wdata(a_wdata),
    .bus_we(a_we), .bus_rdata(a_rdata), .expire_o(a_exp)
  );

  evtimer_top #(.CNT_W(8)) u_nar (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wdata(b_wdata),
    .bus_we(b_we), .bus_rdata(b_rdata), .expire_o(b_exp)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit n, input logic [7:0] a, input logic [31:0] d);
    if (!n) begin a_addr = a; a_wdata = d; a_we = 1'b1; end
    else    begin b_addr = a; b_wdata = d; b_we = 1'b1; end
    @(negedge clk);
    a_we = 1'b0;
    b_we = 1'b0;
  endtask

  task automatic rd(input bit n, input logic [7:0] a, output logic [31:0] d);
    if (!n) a_addr = a; else b_addr = a;
    #1;
    d = n ? b_rdata : a_rdata;
  endtask

  task automatic watch(input bit n, input int cyc, output int hits,
                       output int first, output int last);
    hits = 0; first = 0; last = 0;
    for (int i = 1; i <= cyc; i++) begin
      @(negedge clk);
      #1;
      if (n ? b_exp : a_exp) begin
        hits++;
        if (first == 0) first = i;
        last = i;
      end
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, A_COUNT, v); chk(v == 0, "R1 count", v, 0);
    rd(0, A_MATCH, v); chk(v == 32'hFFFF_FFFF, "R1 match", v, 32'hFFFF_FFFF);
    rd(0, A_CTRL, v);  chk(v == 0, "R1 ctrl", v, 0);
    rd(0, A_DIV, v);   chk(v == 0, "R1 div", v, 0);
    rd(0, A_LOCK, v);  chk(v == 0, "R1 lock", v, 0);
    chk(a_exp == 1'b0, "R1 expire", {31'b0, a_exp}, 0);
    rd(0, 8'h10, v);   chk(v == 0, "R10 unmapped", v, 0);
  endtask

  task automatic t_prescale(input int code);
    logic [31:0] v, exp;
    wr(0, A_DIV, code);
    wr(0, A_CLEAR, 0);
    wr(0, A_CTRL, 1);
    repeat (11) @(negedge clk);
    wr(0, A_CTRL, 0);
    exp = 12 / (code + 1);
    rd(0, A_COUNT, v); chk(v == exp, "R3 divided rate", v, exp);
    repeat (5) @(negedge clk);
    rd(0, A_COUNT, v); chk(v == exp, "R2 hold when stopped", v, exp);
  endtask

  task automatic t_expire();
    int h, f, l;
    wr(0, A_DIV, 0); wr(0, A_MATCH, 5); wr(0, A_CLEAR, 0); wr(0, A_CTRL, 1);
    watch(0, 10, h, f, l);
    chk(h == 1, "R5 pulse count", h, 1);
    chk(f == 5, "R5 pulse cycle", f, 5);
    wr(0, A_CTRL, 0);
  endtask

  task automatic t_zero_on_match();
    int h, f, l;
    logic [31:0] v;
    wr(0, A_MATCH, 3); wr(0, A_CLEAR, 0); wr(0, A_CTRL, 3);
    watch(0, 8, h, f, l);
    chk(h == 2 && f == 3 && l == 7, "R7 reload hits", h, 2);
    wr(0, A_CTRL, 0);
    rd(0, A_COUNT, v); chk(v == 1, "R7 reload count", v, 1);
    wr(0, A_CLEAR, 0); wr(0, A_CTRL, 1);
    watch(0, 8, h, f, l);
    chk(h == 1 && f == 3, "R7 run past hits", h, 1);
    wr(0, A_CTRL, 0);
    rd(0, A_COUNT, v); chk(v == 9, "R7 run past count", v, 9);
  endtask

  task automatic t_collide();
    int h, f, l;
    logic [31:0] v;
    wr(0, A_MATCH, 4); wr(0, A_CLEAR, 0); wr(0, A_CTRL, 1);
    repeat (3) @(negedge clk);
    wr(0, A_CLEAR, 0);
    #1;
    chk(a_exp == 1'b0, "R4 no pulse on clear", {31'b0, a_exp}, 0);
    rd(0, A_COUNT, v); chk(v == 0, "R4 clear wins", v, 0);
    watch(0, 6, h, f, l);
    chk(h == 1 && f == 4, "R4 refire after clear", f, 4);
    wr(0, A_CTRL, 0);
  endtask

  task automatic t_quiet();
    int h, f, l;
    logic [31:0] cur, v;
    rd(0, A_COUNT, cur);
    wr(0, A_MATCH, cur);
    watch(0, 4, h, f, l); chk(h == 0, "R6 match write no pulse", h, 0);
    wr(0, A_MATCH, 0); wr(0, A_CLEAR, 0);
    watch(0, 4, h, f, l); chk(h == 0, "R6 clear onto match no pulse", h, 0);
    wr(0, A_CLEAR, 0); wr(0, A_CTRL, 1);
    repeat (4) @(negedge clk);
    wr(0, A_CTRL, 0);
    wr(0, A_COUNT, 32'h55);
    rd(0, A_COUNT, v); chk(v == 5, "R10 count read-only", v, 5);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    wr(0, A_LOCK, 1);
    rd(0, A_LOCK, v);  chk(v == 1, "R9 lock set", v, 1);
    wr(0, A_MATCH, 32'h77);
    rd(0, A_MATCH, v); chk(v == 0, "R9 match locked", v, 0);
    wr(0, A_CLEAR, 0);
    rd(0, A_COUNT, v); chk(v == 5, "R9 clear locked", v, 5);
    wr(0, A_CTRL, 1);
    repeat (3) @(negedge clk);
    rd(0, A_COUNT, v); chk(v == 5, "R9 ctrl locked count", v, 5);
    rd(0, A_CTRL, v);  chk(v == 0, "R9 ctrl locked", v, 0);
    wr(0, A_DIV, 2);
    rd(0, A_DIV, v);   chk(v == 0, "R9 div locked", v, 0);
    wr(0, A_LOCK, 0);
    rd(0, A_LOCK, v);  chk(v == 0, "R9 unlock", v, 0);
    wr(0, A_CLEAR, 0);
    rd(0, A_COUNT, v); chk(v == 0, "R9 clear after unlock", v, 0);
  endtask

  task automatic t_wrap();
    int h, f, l;
    wr(1, A_MATCH, 2); wr(1, A_CLEAR, 0); wr(1, A_CTRL, 1);
    watch(1, 260, h, f, l);
    chk(h == 2, "R8 hits across wrap", h, 2);
    chk(f == 2 && l == 258, "R8 wrap position", l, 258);
    wr(1, A_CTRL, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    for (int c = 0; c < 4; c++) t_prescale(c);
    t_expire();
    t_zero_on_match();
    t_collide();
    t_quiet();
    t_lock();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule